// File: doc/BRIEF.md
# Floating-Point Store Exception Status and Trap Arbiter

This block sits beside the store path of a floating-point unit. Each time a store operation completes, it gets the raw exception indications of the conversion, the class of the destination format and the source operand's exponent and mantissa fields. It replaces the eight-bit exception status byte with the bits that this class is allowed to raise. It folds them into a sticky accrued-exception byte and masks the new status with the trap-enable byte. When an enabled exception is present, the block raises a one-cycle trap request. The trap request carries the bit position of the highest-priority enabled exception, which selects a vector.

When no trap is taken, the block pulses a commit strobe instead. That strobe lets the store's final address-register adjustment go ahead. A trap suppresses it. The accrued byte keeps its bits until a synchronous clear. A clear that arrives together with an operation leaves only that operation's contributions.

All results are registered. They appear in the cycle after the operation is presented.

Top module: `fpx_trap_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, stat_byte and acc_byte are 0 and trap_req and addr_commit are 0.
- R2: An operation sampled with op_valid replaces all eight status bits in the next cycle. Without op_valid the status byte holds its value. Status bit positions, from highest to lowest priority: 7 BSUN, 6 SNAN, 5 OPERR, 4 OVFL, 3 UNFL, 2 DZ, 1 INEX2, 0 INEX1.
- R3: Class 0 (integer destination) sets only SNAN, OPERR (from flg_invalid) and INEX2 (from flg_inexact), so the status is the raw set masked with 0x62.
- R4: Class 1 (single/double/extended destination) sets only SNAN, OVFL, UNFL and INEX2, so the status is the raw set masked with 0x5A.
- R5: Class 2 (general) passes all eight indications: flg_bsun, SNAN, flg_invalid, flg_ovfl, flg_unfl, flg_dz, flg_inexact and flg_inex1. Class 3 sets no status bit.
- R6: SNAN is set when src_exp is all ones and src_man is nonzero. An all-ones exponent with a zero mantissa gives no SNAN.
- R7: Accrued bit positions are 7 IOP, 6 OVFL, 5 UNFL, 4 DZ and 3 INEX, and bits 2:0 read 0. IOP takes BSUN|SNAN|OPERR, OVFL takes OVFL, DZ takes DZ, and INEX takes INEX1|INEX2|OVFL of the new status.
- R8: Accrued UNFL is set only by an operation whose status has both UNFL and INEX2.
- R9: Accrued bits are sticky. acc_clr zeroes them in the next cycle. When acc_clr and op_valid come in the same cycle, the accrued byte becomes that operation's contributions alone.
- R10: trap_req is a one-cycle pulse, one cycle after an operation whose new status ANDed with trap_en is nonzero.
- R11: With trap_req, trap_idx is the bit position (7..0) of the most significant set bit of status AND trap_en.
- R12: addr_commit pulses one cycle after an operation that does not trap. It is never high together with trap_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A store operation completes this cycle |
| fmt_cls | input | 2 | Destination class: 0 integer, 1 float, 2 general, 3 none |
| flg_bsun | input | 1 | Unordered-branch indication |
| flg_invalid | input | 1 | Invalid-operation indication |
| flg_ovfl | input | 1 | Overflow indication |
| flg_unfl | input | 1 | Underflow indication |
| flg_dz | input | 1 | Divide-by-zero indication |
| flg_inexact | input | 1 | Inexact-result indication |
| flg_inex1 | input | 1 | Inexact-input indication |
| src_exp | input | EXP_W | Source exponent field |
| src_man | input | MAN_W | Source mantissa field |
| trap_en | input | 8 | Trap-enable byte, same layout as the status |
| acc_clr | input | 1 | Synchronous clear of the accrued byte |
| stat_byte | output | 8 | Exception status of the last operation |
| acc_byte | output | 8 | Sticky accrued exceptions |
| trap_req | output | 1 | Trap request pulse |
| trap_idx | output | 3 | Bit position of the trapping exception |
| addr_commit | output | 1 | Address-register update allowed |

## Verification
Two actions can fall in the same cycle: an accrued clear and a new operation's merge. The bench provokes this by raising acc_clr together with op_valid after the accrued byte has been loaded with unrelated bits. It expects only the new operation's contributions to remain. A second collision is a trap decision and the commit strobe. Operations with and without enabled flags run back to back, and every result cycle is checked for exactly one of the two.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

   localparam int STW   = 8;
   localparam int IDX_W = $clog2(STW);

   // status bit positions; order is the trap priority
   localparam int SB_BSUN  = 7;
   localparam int SB_SNAN  = 6;
   localparam int SB_OPERR = 5;
   localparam int SB_OVFL  = 4;
   localparam int SB_UNFL  = 3;
   localparam int SB_DZ    = 2;
   localparam int SB_INEX2 = 1;
   localparam int SB_INEX1 = 0;

   // accrued bit positions
   localparam int AB_IOP  = 7;
   localparam int AB_OVFL = 6;
   localparam int AB_UNFL = 5;
   localparam int AB_DZ   = 4;
   localparam int AB_INEX = 3;

   typedef enum logic [1:0] {
      FC_INT = 2'd0,
      FC_FLT = 2'd1,
      FC_GEN = 2'd2,
      FC_RSV = 2'd3
   } fmt_cls_e;

   localparam logic [STW-1:0] MASK_INT =
      (STW'(1) << SB_SNAN) | (STW'(1) << SB_OPERR) | (STW'(1) << SB_INEX2);
   localparam logic [STW-1:0] MASK_FLT =
      (STW'(1) << SB_SNAN) | (STW'(1) << SB_OVFL) |
      (STW'(1) << SB_UNFL) | (STW'(1) << SB_INEX2);

   typedef struct packed {
      logic bsun;
      logic invalid;
      logic ovfl;
      logic unfl;
      logic dz;
      logic inexact;
      logic inex1;
   } raw_flags_t;

   function automatic logic [STW-1:0] accrue_contrib(input logic [STW-1:0] st);
      logic [STW-1:0] c;
      c          = '0;
      c[AB_IOP]  = st[SB_BSUN] | st[SB_SNAN] | st[SB_OPERR];
      c[AB_OVFL] = st[SB_OVFL];
      c[AB_UNFL] = st[SB_UNFL] & st[SB_INEX2];
      c[AB_DZ]   = st[SB_DZ];
      c[AB_INEX] = st[SB_INEX1] | st[SB_INEX2] | st[SB_OVFL];
      return c;
   endfunction

endpackage

// File: rtl/fpx_snan_detect.sv
module fpx_snan_detect #(
   parameter int EXP_W = 15,
   parameter int MAN_W = 64
) (
   input  logic [EXP_W-1:0] exp_f,
   input  logic [MAN_W-1:0] man_f,
   output logic             snan
);
   logic exp_ones;
   logic man_nz;

   assign exp_ones = &exp_f;
   assign man_nz   = |man_f;
   assign snan     = exp_ones & man_nz;
endmodule

// File: rtl/fpx_status_map.sv
module fpx_status_map
   import fpx_pkg::*;
#(
   parameter bit HAS_GEN_CLASS = 1'b1
) (
   input  logic [1:0]     cls,
   input  raw_flags_t     raw,
   input  logic           snan,
   output logic [STW-1:0] status
);
   logic [STW-1:0] full;
   logic [STW-1:0] keep;

   always_comb begin
      full           = '0;
      full[SB_BSUN]  = raw.bsun;
      full[SB_SNAN]  = snan;
      full[SB_OPERR] = raw.invalid;
      full[SB_OVFL]  = raw.ovfl;
      full[SB_UNFL]  = raw.unfl;
      full[SB_DZ]    = raw.dz;
      full[SB_INEX2] = raw.inexact;
      full[SB_INEX1] = raw.inex1;
   end

   generate
      if (HAS_GEN_CLASS) begin : g_gen
         always_comb begin
            unique case (fmt_cls_e'(cls))
               FC_INT:  keep = MASK_INT;
               FC_FLT:  keep = MASK_FLT;
               FC_GEN:  keep = '1;
               default: keep = '0;
            endcase
         end
      end else begin : g_nogen
         always_comb begin
            unique case (fmt_cls_e'(cls))
               FC_INT:  keep = MASK_INT;
               FC_FLT:  keep = MASK_FLT;
               default: keep = '0;
            endcase
         end
      end
   endgenerate

   assign status = full & keep;
endmodule

// File: rtl/fpx_accrue.sv
module fpx_accrue
   import fpx_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           upd,
   input  logic           clr,
   input  logic [STW-1:0] status,
   output logic [STW-1:0] acc
);
   logic [STW-1:0] contrib;
   logic [STW-1:0] acc_q;
   logic [STW-1:0] acc_d;

   assign contrib = upd ? accrue_contrib(status) : '0;

   always_comb begin
      if (clr) acc_d = contrib;
      else     acc_d = acc_q | contrib;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
   end

   assign acc = acc_q;
endmodule

// File: rtl/fpx_prio_enc.sv
module fpx_prio_enc #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   logic [N-1:0] above;
   logic [N-1:0] grant;

   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_chain
         if (i == N-1) begin : g_top
            assign above[i] = 1'b0;
         end else begin : g_mid
            assign above[i] = above[i+1] | req[i+1];
         end
         assign grant[i] = req[i] & ~above[i];
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int k = 0; k < N; k++) begin
         if (grant[k]) idx = idx | IW'(k);
      end
   end

   assign any = |req;
endmodule

// File: rtl/fpx_trap_arbiter.sv
module fpx_trap_arbiter
   import fpx_pkg::*;
#(
   parameter int EXP_W         = 15,
   parameter int MAN_W         = 64,
   parameter bit HAS_GEN_CLASS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [1:0]       fmt_cls,
   input  logic             flg_bsun,
   input  logic             flg_invalid,
   input  logic             flg_ovfl,
   input  logic             flg_unfl,
   input  logic             flg_dz,
   input  logic             flg_inexact,
   input  logic             flg_inex1,
   input  logic [EXP_W-1:0] src_exp,
   input  logic [MAN_W-1:0] src_man,
   input  logic [7:0]       trap_en,
   input  logic             acc_clr,
   output logic [7:0]       stat_byte,
   output logic [7:0]       acc_byte,
   output logic             trap_req,
   output logic [2:0]       trap_idx,
   output logic             addr_commit
);
   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("fpx_trap_arbiter: EXP_W must be at least 2");
      end
      if (MAN_W < 1) begin : g_bad_man
         $error("fpx_trap_arbiter: MAN_W must be at least 1");
      end
      if (IDX_W != 3) begin : g_bad_idx
         $error("fpx_trap_arbiter: status width must give a 3-bit index");
      end
   endgenerate

   raw_flags_t       raw;
   logic             snan;
   logic [STW-1:0]   stat_new;
   logic [STW-1:0]   armed;
   logic             hit;
   logic [IDX_W-1:0] hit_idx;

   logic [STW-1:0]   stat_q;
   logic             trap_q;
   logic [IDX_W-1:0] idx_q;
   logic             commit_q;

   assign raw = '{bsun:    flg_bsun,
                  invalid: flg_invalid,
                  ovfl:    flg_ovfl,
                  unfl:    flg_unfl,
                  dz:      flg_dz,
                  inexact: flg_inexact,
                  inex1:   flg_inex1};

   fpx_snan_detect #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_snan (
      .exp_f (src_exp),
      .man_f (src_man),
      .snan  (snan)
   );

   fpx_status_map #(.HAS_GEN_CLASS(HAS_GEN_CLASS)) u_map (
      .cls    (fmt_cls),
      .raw    (raw),
      .snan   (snan),
      .status (stat_new)
   );

   assign armed = stat_new & trap_en;

   fpx_prio_enc #(.N(STW)) u_prio (
      .req (armed),
      .any (hit),
      .idx (hit_idx)
   );

   fpx_accrue u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd    (op_valid),
      .clr    (acc_clr),
      .status (stat_new),
      .acc    (acc_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q   <= '0;
         trap_q   <= 1'b0;
         idx_q    <= '0;
         commit_q <= 1'b0;
      end else begin
         trap_q   <= op_valid & hit;
         commit_q <= op_valid & ~hit;
         if (op_valid) begin
            stat_q <= stat_new;
            idx_q  <= hit ? hit_idx : '0;
         end
      end
   end

   assign stat_byte   = stat_q;
   assign trap_req    = trap_q;
   assign trap_idx    = idx_q;
   assign addr_commit = commit_q;
endmodule

// File: rtl/fpx_trap_arbiter_chk.sv
module fpx_trap_arbiter_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       op_valid,
   input logic [1:0] fmt_cls,
   input logic [7:0] trap_en,
   input logic       acc_clr,
   input logic [7:0] stat_byte,
   input logic [7:0] acc_byte,
   input logic       trap_req,
   input logic [2:0] trap_idx,
   input logic       addr_commit
);
   AST_STAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(stat_byte)); // R2

   AST_INT_CLASS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && fmt_cls == 2'd0) |=> ((stat_byte & 8'h9D) == 8'h00)); // R3

   AST_FLT_CLASS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && fmt_cls == 2'd1) |=> ((stat_byte & 8'hA5) == 8'h00)); // R4

   AST_RSV_CLASS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && fmt_cls == 2'd3) |=> (stat_byte == 8'h00)); // R5

   AST_ACC_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      acc_byte[2:0] == 3'b000); // R7

   AST_ACC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_clr |=> ((acc_byte & $past(acc_byte)) == $past(acc_byte))); // R9

   AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_clr && !op_valid) |=> (acc_byte == 8'h00)); // R9

   AST_TRAP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> ((stat_byte & $past(trap_en)) != 8'h00)); // R10

   AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> (!trap_req && !addr_commit)); // R10

   AST_IDX_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (((stat_byte & $past(trap_en)) >> trap_idx) == 8'h01)); // R11

   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> ($countones({trap_req, addr_commit}) == 1)); // R12
endmodule

bind fpx_trap_arbiter fpx_trap_arbiter_chk u_chk (.*);

// File: tb/sim_fpx_trap_arbiter.sv
`timescale 1ns/1ps
module sim_fpx_trap_arbiter;
   localparam int EXP_W = 15;
   localparam int MAN_W = 64;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             op_valid = 1'b0;
   logic [1:0]       fmt_cls = 2'd0;
   logic             flg_bsun = 1'b0, flg_invalid = 1'b0, flg_ovfl = 1'b0, flg_unfl = 1'b0;
   logic             flg_dz = 1'b0, flg_inexact = 1'b0, flg_inex1 = 1'b0;
   logic [EXP_W-1:0] src_exp = '0;
   logic [MAN_W-1:0] src_man = '0;
   logic [7:0]       trap_en = 8'h00;
   logic             acc_clr = 1'b0;
   logic [7:0]       stat_byte, acc_byte;
   logic             trap_req, addr_commit;
   logic [2:0]       trap_idx;

   int checks = 0;
   int errors = 0;
   logic [7:0] acc_m = 8'h00;
   logic [7:0] last_stat = 8'h00;

   typedef struct {
      logic [7:0] st;
      logic [7:0] ac;
      logic       tr;
      logic [2:0] ix;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   fpx_trap_arbiter #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .fmt_cls(fmt_cls),
      .flg_bsun(flg_bsun), .flg_invalid(flg_invalid), .flg_ovfl(flg_ovfl),
      .flg_unfl(flg_unfl), .flg_dz(flg_dz), .flg_inexact(flg_inexact),
      .flg_inex1(flg_inex1), .src_exp(src_exp), .src_man(src_man),
      .trap_en(trap_en), .acc_clr(acc_clr), .stat_byte(stat_byte),
      .acc_byte(acc_byte), .trap_req(trap_req), .trap_idx(trap_idx),
      .addr_commit(addr_commit)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
      end
   endtask

   // f: {bsun, invalid, ovfl, unfl, dz, inexact, inex1}
   function automatic logic [7:0] model_stat(logic [1:0] c, logic [6:0] f, logic sn);
      logic [7:0] all;
      all = {f[6], sn, f[5], f[4], f[3], f[2], f[1], f[0]};
      case (c)
         2'd0:    return all & 8'h62;  // R3
         2'd1:    return all & 8'h5A;  // R4
         2'd2:    return all;          // R5
         default: return 8'h00;        // R5
      endcase
   endfunction

   function automatic logic [7:0] model_acc(logic [7:0] s);
      logic [7:0] a;
      a = 8'h00;
      a[7] = s[7] | s[6] | s[5];  // R7
      a[6] = s[4];
      a[5] = s[3] & s[1];         // R8
      a[4] = s[2];
      a[3] = s[0] | s[1] | s[4];
      return a;
   endfunction

   // called at a negedge; returns at the following negedge with op_valid still high
   task automatic do_op(input string tag, input logic [1:0] c, input logic [6:0] f,
                        input logic [EXP_W-1:0] e, input logic [MAN_W-1:0] m,
                        input logic [7:0] en, input logic clr);
      exp_t it;
      logic sn;
      logic [7:0] armed;
      op_valid = 1'b1; fmt_cls = c;
      {flg_bsun, flg_invalid, flg_ovfl, flg_unfl, flg_dz, flg_inexact, flg_inex1} = f;
      src_exp = e; src_man = m; trap_en = en; acc_clr = clr;
      sn = (&e) && (m != '0);  // R6
      it.st = model_stat(c, f, sn);
      acc_m = clr ? model_acc(it.st) : (acc_m | model_acc(it.st));  // R9
      it.ac = acc_m;
      armed = it.st & en;
      it.tr = (armed != 8'h00);
      it.ix = 3'd0;
      for (int k = 0; k < 8; k++) if (armed[k]) it.ix = 3'(k);  // R11
      it.tag = tag;
      sb_q.push_back(it);
      last_stat = it.st;
      @(negedge clk);
      acc_clr = 1'b0;
   endtask

   task automatic idle(input int n);
      op_valid = 1'b0; acc_clr = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // monitor: one result per sampled operation
   initial begin
      forever begin
         @(posedge clk);
         if (rst_n && op_valid) begin
            exp_t it;
            @(negedge clk);
            if (sb_q.size() == 0) begin
               check("scoreboard underflow", 0, 1);
            end else begin
               it = sb_q.pop_front();
               check({it.tag, " R2 status"}, 32'(stat_byte), 32'(it.st));
               check({it.tag, " R9 accrued"}, 32'(acc_byte), 32'(it.ac));
               check({it.tag, " R10 trap"}, 32'(trap_req), 32'(it.tr));
               check({it.tag, " R12 commit"}, 32'(addr_commit), 32'(!it.tr));
               if (it.tr) check({it.tag, " R11 index"}, 32'(trap_idx), 32'(it.ix));
            end
         end
      end
   end

   initial begin
      #1ms;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   localparam logic [EXP_W-1:0] EONES = '1;

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset status", 32'(stat_byte), 0);
      check("R1 reset accrued", 32'(acc_byte), 0);
      check("R1 reset trap", 32'(trap_req), 0);
      check("R1 reset commit", 32'(addr_commit), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset status", 32'(stat_byte), 0);

      do_op("R3 int all flags", 2'd0, 7'h7F, '0, '0, 8'h00, 1'b0);
      do_op("R2 clean op", 2'd0, 7'h00, '0, '0, 8'h00, 1'b0);
      do_op("R4 flt all flags", 2'd1, 7'h7F, '0, '0, 8'h00, 1'b0);
      idle(2);
      check("R2 status holds", 32'(stat_byte), 32'(last_stat));
      check("R10 no trap when idle", 32'(trap_req), 0);
      check("R12 no commit when idle", 32'(addr_commit), 0);

      op_valid = 1'b0; acc_clr = 1'b1;
      @(negedge clk);
      acc_clr = 1'b0; acc_m = 8'h00;
      check("R9 clear alone", 32'(acc_byte), 0);

      do_op("R8 unfl without inexact", 2'd1, 7'b0001000, '0, '0, 8'h00, 1'b0);
      do_op("R8 unfl with inexact", 2'd1, 7'b0001010, '0, '0, 8'h00, 1'b0);
      do_op("R10 flt ovfl trap", 2'd1, 7'b0010000, '0, '0, 8'h10, 1'b0);
      do_op("R6 snan trap", 2'd0, 7'h00, EONES, 64'h1, 8'h40, 1'b0);
      do_op("R6 inf no snan", 2'd0, 7'h00, EONES, '0, 8'h40, 1'b0);
      do_op("R6 exp not ones", 2'd1, 7'h00, EONES - 1'b1, 64'hFF, 8'hFF, 1'b0);
      do_op("R5 gen all en all", 2'd2, 7'h7F, EONES, 64'h8, 8'hFF, 1'b0);
      do_op("R11 gen low enable", 2'd2, 7'h7F, EONES, 64'h8, 8'h05, 1'b0);
      do_op("R11 gen dz only", 2'd2, 7'b0000100, '0, '0, 8'h3F, 1'b0);
      do_op("R5 reserved class", 2'd3, 7'h7F, EONES, 64'h3, 8'hFF, 1'b0);
      do_op("R9 clear with op", 2'd0, 7'b0000010, '0, '0, 8'h00, 1'b1);
      do_op("R7 gen bsun inex1", 2'd2, 7'b1000001, '0, '0, 8'h00, 1'b0);
      idle(1);

      for (int n = 0; n < 60; n++) begin
         logic [1:0] c;
         logic [6:0] f;
         logic [7:0] en;
         logic big;
         c   = 2'($urandom_range(0, 3));
         f   = 7'($urandom);
         en  = 8'($urandom) & 8'($urandom);
         big = ($urandom_range(0, 3) == 0);
         do_op("R10 random", c, f, big ? EONES : EXP_W'($urandom),
               MAN_W'($urandom_range(0, 1)), en, ($urandom_range(0, 9) == 0));
         if ($urandom_range(0, 4) == 0) idle(1);
      end
      idle(3);
      check("R2 queue drained", 32'(sb_q.size()), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule